// File: doc/BRIEF.md
# Sparse Backplane Slot Connection Store

This block sits between a 32-stream time-division backplane and a local byte store. It does not hold a map entry for every backplane slot. It keeps a small table of connection entries instead. Each entry gives a backplane stream, a backplane slot, a direction and a local slot. A position counter walks the frame one stream-slot per `step` pulse. Stream is the fast index and slot is the slow one. For each position, the block finds every valid entry whose stream and slot equal that position. It then takes one of two actions. It can drive the local byte onto the backplane transmit lane. It can also capture the receive byte into the local store.

Backplane rates are set per group of four consecutive streams. A slower group has fewer live slots per frame, and positions beyond them never match. Software rewrites entries and group rates while traffic runs. Those writes go to a staged copy, and that copy becomes active only at the frame boundary. A frame therefore never switches with a half-updated table. When two drive entries claim the same position, the lower-numbered entry wins and a sticky flag records the clash. The local store also has a plain byte write port and a plain byte read port for the local side.

Top module: `bp_conn_store`

## Requirements
- R1: After reset the position is stream 0, slot 0. The transmit enable is low and the conflict flag is clear. Every entry is invalid and every local byte is zero.
- R2: Each cycle with `step` high advances the position. The stream increments first. After stream STREAMS-1 the stream returns to 0 and the slot increments. After slot SLOTS-1 the slot returns to 0. A cycle without `step` leaves the position unchanged.
- R3: The rate code for stream s is bits [2*(s/4)+1 : 2*(s/4)] of `grp_rate`. Code 0 gives SLOTS/4 live slots, code 1 gives SLOTS/2, and codes 2 and 3 give SLOTS. The code is sampled at the frame boundary. A position whose slot is at or above the live count never drives and never captures.
- R4: While the position equals the stream and slot of a valid entry with `cfg_drive`=1, `bus_tx_en` is high and `bus_tx` carries the local byte at that entry's local slot. Both are combinational in the cycle the position is current.
- R5: On a `step` cycle whose position matches a valid entry with `cfg_drive`=0, `bus_rx` is written into the local byte at that entry's local slot at the clock edge.
- R6: A `cfg_we` write stores the entry into a staged table. That write and any `grp_rate` change affect matching only from the first frame boundary after it. A frame boundary is the step from stream STREAMS-1, slot SLOTS-1.
- R7: An entry written with `cfg_valid`=0 never drives and never captures.
- R8: If several valid drive entries match one position, the lowest entry index supplies the byte. The `conflict` output goes high from the cycle after such a step and stays high until reset.
- R9: `loc_we` writes `loc_wdata` to local byte `loc_waddr`, and `loc_rdata` shows the byte at `loc_raddr` combinationally. A capture to the same byte in the same cycle takes precedence.
- R10: While `bus_tx_en` is low, `bus_tx` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Advance one backplane stream-slot position |
| bus_rx | input | DW | Receive byte at the current position |
| bus_tx | output | DW | Transmit byte at the current position |
| bus_tx_en | output | 1 | Drive enable for the current position |
| pos_stream | output | SW | Current backplane stream |
| pos_slot | output | TW | Current backplane slot |
| grp_rate | input | 2*NG | Rate code per group of four streams |
| cfg_we | input | 1 | Write one staged entry |
| cfg_idx | input | EW | Entry index to write |
| cfg_valid | input | 1 | Entry valid bit |
| cfg_drive | input | 1 | 1: local to backplane, 0: backplane to local |
| cfg_stream | input | SW | Entry backplane stream |
| cfg_slot | input | TW | Entry backplane slot |
| cfg_local | input | LW | Entry local slot |
| loc_we | input | 1 | Local byte write enable |
| loc_waddr | input | LW | Local byte write address |
| loc_wdata | input | DW | Local byte write data |
| loc_raddr | input | LW | Local byte read address |
| loc_rdata | output | DW | Local byte read data |
| conflict | output | 1 | Sticky flag for a drive clash |

## Verification
The hardest case is an entry rewritten in the middle of a frame when its new position still lies ahead in that same frame. In that case the position must pass by silently once and then drive in the following frame. The bench counts exactly 40 steps into a frame and rewrites an entry to a position later in that frame. In the same cycle it raises the rate of a slow group. It then checks both positions over two frames. The bench runs a small configuration through four full frames with a per-position model. That model covers clashing drive entries, an invalid entry at position zero, and captures that fall in a slow group's dead slots.

// File: rtl/bpsw_pkg.sv
package bpsw_pkg;

    // streams sharing one rate setting
    localparam int GROUP_SIZE  = 4;
    localparam int GROUP_SHIFT = 2;

    // rate codes, slowest first
    localparam logic [1:0] RATE_SLOW = 2'd0;
    localparam logic [1:0] RATE_MID  = 2'd1;

    // number of slots that carry traffic in a frame for a rate code
    function automatic int live_slots(input logic [1:0] code, input int slots);
        case (code)
            RATE_SLOW: return slots / 4;
            RATE_MID:  return slots / 2;
            default:   return slots;
        endcase
    endfunction

endpackage

// File: rtl/bp_conn_table.sv
module bp_conn_table #(
    parameter int N  = 512,
    parameter int EW = 9,
    parameter int SW = 5,
    parameter int TW = 7,
    parameter int LW = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [EW-1:0]         idx,
    input  logic                  w_valid,
    input  logic                  w_drive,
    input  logic [SW-1:0]         w_stream,
    input  logic [TW-1:0]         w_slot,
    input  logic [LW-1:0]         w_local,
    input  logic                  commit,
    output logic [N-1:0]          act_valid,
    output logic [N-1:0]          act_drive,
    output logic [N-1:0][SW-1:0]  act_stream,
    output logic [N-1:0][TW-1:0]  act_slot,
    output logic [N-1:0][LW-1:0]  act_local
);

    typedef struct packed {
        logic [N-1:0]         valid;
        logic [N-1:0]         drive;
        logic [N-1:0][SW-1:0] stream;
        logic [N-1:0][TW-1:0] slot;
        logic [N-1:0][LW-1:0] lcl;
    } table_t;

    typedef struct packed {
        table_t staged;
        table_t active;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.staged.valid[idx]  = w_valid;
            st_d.staged.drive[idx]  = w_drive;
            st_d.staged.stream[idx] = w_stream;
            st_d.staged.slot[idx]   = w_slot;
            st_d.staged.lcl[idx]    = w_local;
        end
        // whole staged copy goes live only at a frame boundary
        if (commit) begin
            st_d.active = st_d.staged;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_valid  = st_q.active.valid;
    assign act_drive  = st_q.active.drive;
    assign act_stream = st_q.active.stream;
    assign act_slot   = st_q.active.slot;
    assign act_local  = st_q.active.lcl;

endmodule

// File: rtl/bp_match.sv
module bp_match #(
    parameter int N  = 512,
    parameter int SW = 5,
    parameter int TW = 7,
    parameter int LW = 10
) (
    input  logic [N-1:0]          act_valid,
    input  logic [N-1:0]          act_drive,
    input  logic [N-1:0][SW-1:0]  act_stream,
    input  logic [N-1:0][TW-1:0]  act_slot,
    input  logic [N-1:0][LW-1:0]  act_local,
    input  logic [SW-1:0]         cur_stream,
    input  logic [TW-1:0]         cur_slot,
    input  logic                  live,
    output logic                  drv_hit,
    output logic [LW-1:0]         drv_local,
    output logic                  drv_multi,
    output logic                  cap_hit,
    output logic [LW-1:0]         cap_local
);

    logic [N-1:0] hit_drv;
    logic [N-1:0] hit_cap;

    // one address comparator per stored entry
    for (genvar i = 0; i < N; i++) begin : g_cmp
        logic at_pos;
        assign at_pos     = live && act_valid[i]
                            && (act_stream[i] == cur_stream)
                            && (act_slot[i] == cur_slot);
        assign hit_drv[i] = at_pos && act_drive[i];
        assign hit_cap[i] = at_pos && !act_drive[i];
    end

    // lowest index wins: scan downward so the last hit seen is the lowest
    always_comb begin
        drv_local = '0;
        cap_local = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_drv[i]) drv_local = act_local[i];
            if (hit_cap[i]) cap_local = act_local[i];
        end
    end

    assign drv_hit   = |hit_drv;
    assign cap_hit   = |hit_cap;
    assign drv_multi = |(hit_drv & (hit_drv - N'(1)));

endmodule

// File: rtl/bp_local_mem.sv
module bp_local_mem #(
    parameter int DEPTH = 1024,
    parameter int LW    = 10,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_we,
    input  logic [LW-1:0] cap_addr,
    input  logic [DW-1:0] cap_data,
    input  logic          loc_we,
    input  logic [LW-1:0] loc_addr,
    input  logic [DW-1:0] loc_data,
    input  logic [LW-1:0] drv_addr,
    output logic [DW-1:0] drv_data,
    input  logic [LW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] bytes;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (loc_we) st_d.bytes[loc_addr] = loc_data;
        // backplane capture overrides a local write to the same byte
        if (cap_we) st_d.bytes[cap_addr] = cap_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign drv_data = st_q.bytes[drv_addr];
    assign rd_data  = st_q.bytes[rd_addr];

endmodule

// File: rtl/bp_conn_store.sv
module bp_conn_store
    import bpsw_pkg::*;
#(
    parameter int STREAMS     = 32,
    parameter int SLOTS       = 128,
    parameter int ENTRIES     = 512,
    parameter int LOCAL_SLOTS = 1024,
    parameter int DW          = 8,
    localparam int SW = $clog2(STREAMS),
    localparam int TW = $clog2(SLOTS),
    localparam int EW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int LW = $clog2(LOCAL_SLOTS),
    localparam int NG = STREAMS / GROUP_SIZE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [DW-1:0] bus_rx,
    output logic [DW-1:0] bus_tx,
    output logic          bus_tx_en,
    output logic [SW-1:0] pos_stream,
    output logic [TW-1:0] pos_slot,
    input  logic [2*NG-1:0] grp_rate,
    input  logic          cfg_we,
    input  logic [EW-1:0] cfg_idx,
    input  logic          cfg_valid,
    input  logic          cfg_drive,
    input  logic [SW-1:0] cfg_stream,
    input  logic [TW-1:0] cfg_slot,
    input  logic [LW-1:0] cfg_local,
    input  logic          loc_we,
    input  logic [LW-1:0] loc_waddr,
    input  logic [DW-1:0] loc_wdata,
    input  logic [LW-1:0] loc_raddr,
    output logic [DW-1:0] loc_rdata,
    output logic          conflict
);

    localparam int GW = SW - GROUP_SHIFT;

    typedef struct packed {
        logic [SW-1:0]       stream;
        logic [TW-1:0]       slot;
        logic [NG-1:0][1:0]  rate;
        logic                conflict;
    } state_t;

    state_t st_d, st_q;

    logic [ENTRIES-1:0]         act_valid;
    logic [ENTRIES-1:0]         act_drive;
    logic [ENTRIES-1:0][SW-1:0] act_stream;
    logic [ENTRIES-1:0][TW-1:0] act_slot;
    logic [ENTRIES-1:0][LW-1:0] act_local;

    logic          slot_live;
    logic          frame_wrap;
    logic [GW-1:0] grp;
    logic          drv_hit, drv_multi, cap_hit;
    logic [LW-1:0] drv_local, cap_local;
    logic [DW-1:0] drv_data;

    always_comb begin
        grp        = st_q.stream[SW-1:GROUP_SHIFT];
        slot_live  = (32'(st_q.slot) < 32'(live_slots(st_q.rate[grp], SLOTS)));
        frame_wrap = step && (st_q.stream == SW'(STREAMS - 1))
                          && (st_q.slot == TW'(SLOTS - 1));
        st_d = st_q;
        if (step) begin
            if (st_q.stream == SW'(STREAMS - 1)) begin
                st_d.stream = '0;
                st_d.slot   = st_q.slot + TW'(1);
            end else begin
                st_d.stream = st_q.stream + SW'(1);
            end
            if (drv_multi) st_d.conflict = 1'b1;
        end
        if (frame_wrap) st_d.rate = grp_rate;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    bp_conn_table #(
        .N (ENTRIES), .EW(EW), .SW(SW), .TW(TW), .LW(LW)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .idx       (cfg_idx),
        .w_valid   (cfg_valid),
        .w_drive   (cfg_drive),
        .w_stream  (cfg_stream),
        .w_slot    (cfg_slot),
        .w_local   (cfg_local),
        .commit    (frame_wrap),
        .act_valid (act_valid),
        .act_drive (act_drive),
        .act_stream(act_stream),
        .act_slot  (act_slot),
        .act_local (act_local)
    );

    bp_match #(
        .N (ENTRIES), .SW(SW), .TW(TW), .LW(LW)
    ) u_match (
        .act_valid (act_valid),
        .act_drive (act_drive),
        .act_stream(act_stream),
        .act_slot  (act_slot),
        .act_local (act_local),
        .cur_stream(st_q.stream),
        .cur_slot  (st_q.slot),
        .live      (slot_live),
        .drv_hit   (drv_hit),
        .drv_local (drv_local),
        .drv_multi (drv_multi),
        .cap_hit   (cap_hit),
        .cap_local (cap_local)
    );

    bp_local_mem #(
        .DEPTH(LOCAL_SLOTS), .LW(LW), .DW(DW)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_we  (step && cap_hit),
        .cap_addr(cap_local),
        .cap_data(bus_rx),
        .loc_we  (loc_we),
        .loc_addr(loc_waddr),
        .loc_data(loc_wdata),
        .drv_addr(drv_local),
        .drv_data(drv_data),
        .rd_addr (loc_raddr),
        .rd_data (loc_rdata)
    );

    assign bus_tx_en  = drv_hit;
    assign bus_tx     = drv_hit ? drv_data : '0;
    assign pos_stream = st_q.stream;
    assign pos_slot   = st_q.slot;
    assign conflict   = st_q.conflict;

endmodule

// File: rtl/bp_conn_store_chk.sv
module bp_conn_store_chk #(
    parameter int STREAMS = 32,
    parameter int N       = 512,
    parameter int SW      = 5,
    parameter int TW      = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          step,
    input logic [SW-1:0] pos_stream,
    input logic [TW-1:0] pos_slot,
    input logic          bus_tx_en,
    input logic          conflict,
    input logic          live,
    input logic          wrap,
    input logic [N-1:0]  act_valid
);

    // R2: position frozen without a step
    a_r2_hold_pos: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(pos_stream) && $stable(pos_slot)));

    // R2: stream is the fast index
    a_r2_stream_first: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (pos_stream != SW'(STREAMS - 1)))
        |=> ((pos_stream == $past(pos_stream) + SW'(1)) && $stable(pos_slot)));

    // R3: dead slots of a slow group never drive
    a_r3_quiet_dead_slot: assert property (@(posedge clk) disable iff (!rst_n)
        !live |-> !bus_tx_en);

    // R6: the active table moves only at a frame boundary
    a_r6_commit_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !(step && wrap) |=> $stable(act_valid));

    // R8: conflict flag is sticky
    a_r8_conflict_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |=> conflict);

endmodule

bind bp_conn_store bp_conn_store_chk #(
    .STREAMS(STREAMS), .N(ENTRIES), .SW(SW), .TW(TW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .pos_stream(pos_stream),
    .pos_slot  (pos_slot),
    .bus_tx_en (bus_tx_en),
    .conflict  (conflict),
    .live      (slot_live),
    .wrap      (frame_wrap),
    .act_valid (act_valid)
);

// File: tb/bp_conn_store_test.sv
module bp_conn_store_test;

    localparam int CLK_PERIOD = 10;
    localparam int STREAMS = 8;
    localparam int SLOTS   = 16;
    localparam int ENTRIES = 8;
    localparam int LOCALS  = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step = 1'b0;
    logic [7:0] bus_rx = '0;
    logic [7:0] bus_tx;
    logic       bus_tx_en;
    logic [2:0] pos_stream;
    logic [3:0] pos_slot;
    logic [3:0] grp_rate = '0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_idx = '0;
    logic       cfg_valid = 1'b0;
    logic       cfg_drive = 1'b0;
    logic [2:0] cfg_stream = '0;
    logic [3:0] cfg_slot = '0;
    logic [4:0] cfg_local = '0;
    logic       loc_we = 1'b0;
    logic [4:0] loc_waddr = '0;
    logic [7:0] loc_wdata = '0;
    logic [4:0] loc_raddr = '0;
    logic [7:0] loc_rdata;
    logic       conflict;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bp_conn_store #(
        .STREAMS(STREAMS), .SLOTS(SLOTS), .ENTRIES(ENTRIES),
        .LOCAL_SLOTS(LOCALS), .DW(8)
    ) uut (.*);

    int checks = 0;
    int errors = 0;

    // model state
    int sv_valid[ENTRIES], sv_drive[ENTRIES], sv_str[ENTRIES], sv_slot[ENTRIES], sv_loc[ENTRIES];
    int av_valid[ENTRIES], av_drive[ENTRIES], av_str[ENTRIES], av_slot[ENTRIES], av_loc[ENTRIES];
    int m_mem[LOCALS];
    int m_rate[2];
    int m_conf = 0;
    int ms = 0, mt = 0, m_frame = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (frame %0d s%0d t%0d)",
                     tag, act, exp, m_frame, ms, mt);
        end
    endtask

    function automatic int live_cnt(input int code);
        if (code == 0) return SLOTS / 4;
        if (code == 1) return SLOTS / 2;
        return SLOTS;
    endfunction

    task automatic cfg_write(input int i, input int v, input int d,
                             input int s, input int t, input int l);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(i); cfg_valid = v[0]; cfg_drive = d[0];
        cfg_stream = 3'(s); cfg_slot = 4'(t); cfg_local = 5'(l);
        sv_valid[i] = v; sv_drive[i] = d; sv_str[i] = s; sv_slot[i] = t; sv_loc[i] = l;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic loc_write(input int a, input int v);
        @(negedge clk);
        loc_we = 1'b1; loc_waddr = 5'(a); loc_wdata = 8'(v);
        m_mem[a] = v & 255;
        @(negedge clk);
        loc_we = 1'b0;
    endtask

    task automatic loc_check(input int a, input string tag);
        @(negedge clk);
        loc_raddr = 5'(a);
        #1;
        chk(int'(loc_rdata) == m_mem[a], tag, int'(loc_rdata), m_mem[a]);
    endtask

    task automatic one_step();
        int rx, live, dhit, dloc, chit, cloc, nd;
        @(negedge clk);
        rx = (m_frame * 37 + mt * 8 + ms * 5 + 1) & 255;
        step = 1'b1;
        bus_rx = 8'(rx);
        #1;
        live = (mt < live_cnt(m_rate[ms / 4])) ? 1 : 0;
        dhit = 0; dloc = 0; chit = 0; cloc = 0; nd = 0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (live != 0 && av_valid[i] != 0 && av_str[i] == ms && av_slot[i] == mt) begin
                if (av_drive[i] != 0) begin dhit = 1; dloc = av_loc[i]; nd++; end
                else begin chit = 1; cloc = av_loc[i]; end
            end
        end
        // R2: position
        chk(int'(pos_stream) == ms && int'(pos_slot) == mt, "R2",
            int'(pos_slot) * 8 + int'(pos_stream), mt * 8 + ms);
        // R4 / R7 / R3: enable and byte
        chk(int'(bus_tx_en) == dhit, "R4", int'(bus_tx_en), dhit);
        if (dhit != 0)
            chk(int'(bus_tx) == m_mem[dloc], "R4", int'(bus_tx), m_mem[dloc]);
        else
            chk(bus_tx == 8'd0, "R10", int'(bus_tx), 0);
        chk(int'(conflict) == m_conf, "R8", int'(conflict), m_conf);
        // named corner positions
        if (ms == 0 && mt == 0) chk(bus_tx_en == 1'b0, "R7", int'(bus_tx_en), 0);
        if (ms == 6 && mt == 10)
            chk(int'(bus_tx_en) == (m_frame == 3 ? 1 : 0), "R3", int'(bus_tx_en), m_frame == 3 ? 1 : 0);
        if (ms == 3 && mt == 9)
            chk(int'(bus_tx_en) == (m_frame == 3 ? 1 : 0), "R6", int'(bus_tx_en), m_frame == 3 ? 1 : 0);
        if (ms == 1 && mt == 3 && m_frame == 0)
            chk(bus_tx_en == 1'b0, "R6", int'(bus_tx_en), 0);
        if (ms == 1 && mt == 3 && m_frame >= 1)
            chk(int'(bus_tx) == m_mem[5], "R8", int'(bus_tx), m_mem[5]);
        @(posedge clk);
        if (chit != 0) m_mem[cloc] = rx;
        if (nd > 1) m_conf = 1;
        if (ms == STREAMS - 1) begin
            ms = 0;
            if (mt == SLOTS - 1) begin
                mt = 0;
                m_frame++;
                for (int i = 0; i < ENTRIES; i++) begin
                    av_valid[i] = sv_valid[i]; av_drive[i] = sv_drive[i];
                    av_str[i] = sv_str[i]; av_slot[i] = sv_slot[i]; av_loc[i] = sv_loc[i];
                end
                m_rate[0] = int'(grp_rate[1:0]);
                m_rate[1] = int'(grp_rate[3:2]);
            end else begin
                mt++;
            end
        end else begin
            ms++;
        end
    endtask

    task automatic run_steps(input int n);
        for (int k = 0; k < n; k++) one_step();
        @(negedge clk);
        step = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < ENTRIES; i++) begin
            sv_valid[i] = 0; sv_drive[i] = 0; sv_str[i] = 0; sv_slot[i] = 0; sv_loc[i] = 0;
            av_valid[i] = 0; av_drive[i] = 0; av_str[i] = 0; av_slot[i] = 0; av_loc[i] = 0;
        end
        for (int a = 0; a < LOCALS; a++) m_mem[a] = 0;
        m_rate[0] = 0; m_rate[1] = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(pos_stream == 3'd0 && pos_slot == 4'd0, "R1", int'(pos_slot), 0);
        chk(bus_tx_en == 1'b0, "R1", int'(bus_tx_en), 0);
        chk(conflict == 1'b0, "R1", int'(conflict), 0);
        loc_check(0, "R1");
        loc_check(LOCALS - 1, "R1");

        // R9: preload and read back local bytes
        for (int a = 0; a < LOCALS; a++) loc_write(a, a * 7 + 3);
        for (int a = 0; a < LOCALS; a++) loc_check(a, "R9");

        // R3: group 0 full rate, group 1 slow
        grp_rate = 4'b0010;
        cfg_write(0, 1, 1, 1, 3, 5);
        cfg_write(1, 1, 1, 1, 3, 9);    // clashes with entry 0 (R8)
        cfg_write(2, 1, 0, 2, 7, 20);   // capture (R5)
        cfg_write(3, 0, 1, 0, 0, 1);    // invalid (R7)
        cfg_write(4, 1, 1, 5, 2, 12);   // slow group, live slot
        cfg_write(5, 1, 1, 6, 10, 13);  // slow group, dead slot (R3)
        cfg_write(6, 1, 0, 4, 15, 21);  // capture in dead slot until rate rises
        cfg_write(7, 1, 0, 0, 0, 22);   // capture at position zero

        // R2: idle cycles keep position
        @(negedge clk);
        chk(pos_stream == 3'd0 && pos_slot == 4'd0, "R2", int'(pos_slot), 0);

        run_steps(STREAMS * SLOTS);      // frame 0: staged only
        run_steps(STREAMS * SLOTS);      // frame 1: active
        run_steps(40);                   // frame 2, part way
        cfg_write(4, 1, 1, 3, 9, 14);    // R6: ahead in this frame, must wait
        grp_rate = 4'b1010;
        @(negedge clk);
        chk(pos_stream == 3'd0 && pos_slot == 4'd5, "R2", int'(pos_slot), 5);
        run_steps(STREAMS * SLOTS - 40);
        run_steps(STREAMS * SLOTS);      // frame 3

        // R5: captured bytes at the local side
        loc_check(20, "R5");
        loc_check(21, "R5");
        loc_check(22, "R5");
        for (int a = 0; a < LOCALS; a++) loc_check(a, "R5");
        chk(conflict == 1'b1, "R8", int'(conflict), 1);

        finish_run();
    end

endmodule